// File: doc/BRIEF.md
# Serial EEPROM-Style Read Target

This block is a two-wire serial bus target that serves read traffic from a 512-byte array held inside it. It watches already-synchronized clock and data lines and finds start, stop and repeated-start conditions on them. It accepts an eight-bit select code, acknowledges it when the select code is addressed to it, and shifts stored bytes out most significant bit first. It pulls the data line low through an open-drain style output.

One nine-bit address pointer serves every kind of read. A write-type select code followed by one address byte only loads that pointer. Memory is never written over the bus. After that, a repeated start and a read-type select code fetch data from the loaded location. A read-type select code sent on its own reads from wherever the pointer already stands. The master acknowledges each byte it wants more of. It ends the read by withholding the acknowledge and then sending stop. The array is filled through a side port, which serves as the preload path.

Top module: `serialMemReader`

## Requirements
- R1: The write-control input has no effect on acknowledges, read data or pointer movement.
- R2: A select code with bit 0 (direction) = 0 that is accepted, followed by an address byte, sets the pointer to {select bit 1, address byte}. Both bytes are acknowledged, and no array location changes.
- R3: After such an address load, a repeated start and an accepted select code with bit 0 = 1 are acknowledged, and the byte at the loaded pointer is returned MSB first.
- R4: A start followed directly by an accepted select code with bit 0 = 1 returns the byte at the current pointer, which is 0 after reset. Select bit 1 is not used in this case.
- R5: The pointer advances by one each time a byte is loaded for output, and at no other time except an address load.
- R6: When the master withholds the acknowledge on a data byte and then sends stop, the output is released and the target goes idle.
- R7: While the master acknowledges each data byte, the target keeps returning the byte at the next pointer value.
- R8: In a read that follows an address load, a read select code whose bits 7..1 differ from those of the write select code gets no acknowledge, and the target stays off the bus until the next start.
- R9: A select code is accepted only when bits 7..4 = 4'b1010 and bits 3..2 equal the strap input. Any other code gets no acknowledge, and the target ignores the bus until the next start.
- R10: The pointer wraps from 511 to 0 during a multi-byte read.
- R11: A stop or start at any point releases the data output and restarts the protocol state.
- R12: The data output changes only while the bus clock is low, and an acknowledge stays low for the whole ninth clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the bus lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line (wired value) |
| strapSel | input | 2 | Strap bits the select code must match |
| wrCtl | input | 1 | Write-control input, ignored by reads |
| bdWrEn | input | 1 | Preload write enable for the array |
| bdAddr | input | 9 | Preload address |
| bdData | input | 8 | Preload data |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench uses the default parameters: a nine-bit pointer over a 512-entry array and type identifier 4'b1010, with the strap tied to 2'b10. With the full array present, the bench can run reads that cross from the lower 256-byte half into the upper half, and reads that wrap from 511 to 0. It can also exercise select codes that differ from the accepted one only in the type field, only in the strap field, or only in the half-select bit.

// File: rtl/smr_pkg.sv
package smr_pkg;

  // One-cycle strobes from the protocol control to the datapath
  typedef struct packed {
    logic rxShiftEn;  // shift sampled data bit into receive register
    logic hdrSave;    // remember bits 7..1 of a write select code
    logic addrLoad;   // load pointer from saved header and received byte
    logic txLoad;     // fetch byte at pointer, drive its MSB, advance pointer
    logic txShiftEn;  // move to next output bit
    logic ackDrive;   // pull data low for an acknowledge
    logic sdaRelease; // stop pulling data low
  } smrStrobe_t;

endpackage

// File: rtl/smrControl.sv
module smrControl #(
  parameter logic [3:0] TYPE_ID = 4'b1010
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [1:0]              strapSel,
  input  logic [7:0]              rxByte,
  input  logic                    hdrMatch,
  output smr_pkg::smrStrobe_t     strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVSEL, ST_DEV_ACK, ST_ADDR,
    ST_ADDR_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } smrState_t;

  smrState_t state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic sclPrev, sdaPrev;
  logic isRead, isReadNxt;
  logic randPending, pendNxt;
  logic mAck, mAckNxt;

  logic sclRise, sclFall, startEv, stopEv, selOk;

  assign sclRise = sclIn & ~sclPrev;
  assign sclFall = ~sclIn & sclPrev;
  assign startEv = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopEv  = sclIn & sclPrev & ~sdaPrev & sdaIn;
  assign selOk   = (rxByte[7:4] == TYPE_ID) && (rxByte[3:2] == strapSel);

  always_comb begin
    strobe    = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    isReadNxt = isRead;
    pendNxt   = randPending;
    mAckNxt   = mAck;
    if (stopEv) begin
      stateNxt          = ST_IDLE;
      strobe.sdaRelease = 1'b1;
      pendNxt           = 1'b0;
    end else if (startEv) begin
      stateNxt          = ST_DEVSEL;
      bitCntNxt         = '0;
      strobe.sdaRelease = 1'b1;
    end else begin
      case (state)
        ST_DEVSEL, ST_ADDR: begin
          if (sclRise && bitCnt != 4'd8) begin
            strobe.rxShiftEn = 1'b1;
            bitCntNxt        = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntNxt = '0;
            if (state == ST_ADDR) begin
              strobe.addrLoad = 1'b1;
              strobe.ackDrive = 1'b1;
              pendNxt         = 1'b1;
              stateNxt        = ST_ADDR_ACK;
            end else if (!selOk) begin
              stateNxt = ST_WAIT;
            end else if (!rxByte[0]) begin
              strobe.hdrSave  = 1'b1;
              strobe.ackDrive = 1'b1;
              isReadNxt       = 1'b0;
              pendNxt         = 1'b0;
              stateNxt        = ST_DEV_ACK;
            end else if (randPending && !hdrMatch) begin
              pendNxt  = 1'b0;
              stateNxt = ST_WAIT;
            end else begin
              strobe.ackDrive = 1'b1;
              isReadNxt       = 1'b1;
              pendNxt         = 1'b0;
              stateNxt        = ST_DEV_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              strobe.txLoad = 1'b1;
              stateNxt      = ST_RDATA;
            end else begin
              strobe.sdaRelease = 1'b1;
              stateNxt          = ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            strobe.sdaRelease = 1'b1;
            stateNxt          = ST_WAIT;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              strobe.sdaRelease = 1'b1;
              bitCntNxt         = '0;
              stateNxt          = ST_RACK;
            end else begin
              strobe.txShiftEn = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaIn;
          end else if (sclFall) begin
            if (mAck) begin
              strobe.txLoad = 1'b1;
              stateNxt      = ST_RDATA;
            end else begin
              stateNxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      sclPrev     <= 1'b1;
      sdaPrev     <= 1'b1;
      isRead      <= 1'b0;
      randPending <= 1'b0;
      mAck        <= 1'b0;
    end else begin
      state       <= stateNxt;
      bitCnt      <= bitCntNxt;
      sclPrev     <= sclIn;
      sdaPrev     <= sdaIn;
      isRead      <= isReadNxt;
      randPending <= pendNxt;
      mAck        <= mAckNxt;
    end
  end

endmodule

// File: rtl/smrDatapath.sv
module smrDatapath #(
  parameter int MEM_ADDR_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sdaIn,
  input  smr_pkg::smrStrobe_t     strobe,
  input  logic                    bdWrEn,
  input  logic [MEM_ADDR_W-1:0]   bdAddr,
  input  logic [7:0]              bdData,
  output logic [7:0]              rxByte,
  output logic                    hdrMatch,
  output logic [MEM_ADDR_W-1:0]   addrCnt,
  output logic                    sdaDriveLow
);

  localparam int DEPTH = 1 << MEM_ADDR_W;
  localparam int HI_W  = MEM_ADDR_W - 8;

  logic [7:0] memArr [DEPTH];
  logic [7:0] txShift;
  logic [6:0] savedHdr;
  logic [7:0] rdByte;

  assign rdByte   = memArr[addrCnt];
  assign hdrMatch = (rxByte[7:1] == savedHdr);

  always_ff @(posedge clk) begin
    if (bdWrEn) memArr[bdAddr] <= bdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte      <= '0;
      txShift     <= '0;
      savedHdr    <= '0;
      addrCnt     <= '0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (strobe.rxShiftEn) rxByte <= {rxByte[6:0], sdaIn};
      if (strobe.hdrSave)   savedHdr <= rxByte[7:1];
      if (strobe.addrLoad)  addrCnt <= {savedHdr[HI_W-1:0], rxByte};
      if (strobe.txLoad) begin
        txShift     <= rdByte;
        sdaDriveLow <= ~rdByte[7];
        addrCnt     <= addrCnt + 1'b1;
      end else if (strobe.txShiftEn) begin
        txShift     <= {txShift[6:0], 1'b0};
        sdaDriveLow <= ~txShift[6];
      end else if (strobe.ackDrive) begin
        sdaDriveLow <= 1'b1;
      end else if (strobe.sdaRelease) begin
        sdaDriveLow <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serialMemReader.sv
module serialMemReader #(
  parameter int         MEM_ADDR_W = 9,
  parameter logic [3:0] TYPE_ID    = 4'b1010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [1:0]            strapSel,
  input  logic                  wrCtl,
  input  logic                  bdWrEn,
  input  logic [MEM_ADDR_W-1:0] bdAddr,
  input  logic [7:0]            bdData,
  output logic                  sdaDriveLow
);

  smr_pkg::smrStrobe_t   strobe;
  logic [7:0]            rxByte;
  logic                  hdrMatch;
  logic [MEM_ADDR_W-1:0] curAddr;

  smrControl #(.TYPE_ID(TYPE_ID)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapSel(strapSel), .rxByte(rxByte), .hdrMatch(hdrMatch),
    .strobe(strobe)
  );

  smrDatapath #(.MEM_ADDR_W(MEM_ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strobe(strobe),
    .bdWrEn(bdWrEn), .bdAddr(bdAddr), .bdData(bdData),
    .rxByte(rxByte), .hdrMatch(hdrMatch), .addrCnt(curAddr),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/smrChecker.sv
module smrChecker #(
  parameter int MEM_ADDR_W = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaIn,
  input logic                  wrCtl,
  input logic                  sdaDriveLow,
  input logic [MEM_ADDR_W-1:0] curAddr,
  input logic                  txLoad,
  input logic                  addrLoad
);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !$past(sclIn)); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && sdaIn && !$past(sdaIn)) |=> !sdaDriveLow); // R11

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !sdaIn && $past(sdaIn)) |=> !sdaDriveLow); // R11

  AST_ADDR_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curAddr) |-> $past(txLoad || addrLoad)); // R5

  AST_WC_NO_DRIVE_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !$stable(wrCtl)) |=> $stable(sdaDriveLow)); // R1

endmodule

bind serialMemReader smrChecker #(.MEM_ADDR_W(MEM_ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wrCtl(wrCtl),
  .sdaDriveLow(sdaDriveLow), .curAddr(curAddr),
  .txLoad(strobe.txLoad), .addrLoad(strobe.addrLoad)
);

// File: tb/serialMemReader_tb_top.sv
`timescale 1ns/1ps
module serialMemReader_tb_top;

  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic wrCtl = 1'b0;
  logic bdWrEn = 1'b0;
  logic [8:0] bdAddr = '0;
  logic [7:0] bdData = '0;
  logic sdaDriveLow;
  logic sdaLine;

  int nChecks = 0;
  int nFail = 0;
  int modelAddr = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #10 clk = ~clk;

  serialMemReader dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapSel(STRAP), .wrCtl(wrCtl), .bdWrEn(bdWrEn), .bdAddr(bdAddr),
    .bdData(bdData), .sdaDriveLow(sdaDriveLow)
  );

  function automatic logic [7:0] memVal(int a);
    return 8'((a * 29) + (a >> 4) + 8'h5A);
  endfunction

  function automatic logic [7:0] hdr(logic [1:0] s, logic a8, logic rw);
    return {4'b1010, s, a8, rw};
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitN(4);
    sdaM = 1'b0; waitN(4);
    sclM = 1'b0; waitN(2);
  endtask

  task automatic busRepStart();
    sdaM = 1'b1; waitN(2);
    sclM = 1'b1; waitN(4);
    sdaM = 1'b0; waitN(4);
    sclM = 1'b0; waitN(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitN(2);
    sclM = 1'b1; waitN(4);
    sdaM = 1'b1; waitN(4);
  endtask

  // Sends a byte; acknowledge is sampled early and late in the ninth clock high phase
  task automatic sendByte(logic [7:0] b, output logic ackd);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitN(2);
      sclM = 1'b1; waitN(4);
      sclM = 1'b0; waitN(2);
    end
    sdaM = 1'b1; waitN(2);
    sclM = 1'b1; waitN(1);
    a1 = ~sdaLine; waitN(3);
    a2 = ~sdaLine;
    sclM = 1'b0; waitN(2);
    if (a1) checkEq("R12 ack held through ninth clock", a2, 1);
    ackd = a1;
  endtask

  task automatic readByte(logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitN(2);
      sclM = 1'b1; waitN(2);
      b[i] = sdaLine; waitN(2);
      sclM = 1'b0;
    end
    waitN(1);
    sdaM = ~ackIt; waitN(1);
    sclM = 1'b1; waitN(4);
    sclM = 1'b0; waitN(1);
    sdaM = 1'b1; waitN(1);
  endtask

  // Monitor side of the scoreboard: pops the next expected byte and compares
  task automatic monitorByte(logic [7:0] got);
    logic [7:0] exp;
    string tag;
    if (expQ.size() == 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard: unexpected byte actual %0h expected none", got);
    end else begin
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      checkEq(tag, got, exp);
    end
  endtask

  // Driver side: pushes expected bytes, then clocks them out
  task automatic readN(int n, string tag);
    logic [7:0] got;
    for (int k = 0; k < n; k++) begin
      expQ.push_back(memVal(modelAddr));
      tagQ.push_back(tag);
      modelAddr = (modelAddr + 1) % 512;
      readByte(k != n - 1, got);
      monitorByte(got);
    end
  endtask

  task automatic finishRead(string tag);
    busStop();
    waitN(1);
    checkEq({tag, " R6 released after nack and stop"}, sdaDriveLow, 0);
  endtask

  task automatic randomRead(int addr, int n, string tag);
    logic ackd;
    logic [8:0] a9;
    a9 = 9'(addr);
    busStart();
    sendByte(hdr(STRAP, a9[8], 1'b0), ackd);
    checkEq({tag, " R2 write select ack"}, ackd, 1);
    sendByte(a9[7:0], ackd);
    checkEq({tag, " R2 address ack"}, ackd, 1);
    busRepStart();
    sendByte(hdr(STRAP, a9[8], 1'b1), ackd);
    checkEq({tag, " R3 read select ack"}, ackd, 1);
    modelAddr = addr;
    readN(n, tag);
    finishRead(tag);
  endtask

  task automatic currentRead(int n, logic a8, string tag);
    logic ackd;
    busStart();
    sendByte(hdr(STRAP, a8, 1'b1), ackd);
    checkEq({tag, " R4 read select ack"}, ackd, 1);
    readN(n, tag);
    finishRead(tag);
  endtask

  initial begin
    logic ackd;
    logic [7:0] got;
    waitN(3);
    for (int i = 0; i < 512; i++) begin
      bdWrEn = 1'b1; bdAddr = 9'(i); bdData = memVal(i);
      waitN(1);
    end
    bdWrEn = 1'b0;
    waitN(2);
    checkEq("R11 reset leaves output released", sdaDriveLow, 0);
    rstN = 1'b1;
    waitN(4);

    currentRead(1, 1'b1, "R4 current read from reset pointer");
    currentRead(2, 1'b0, "R7 current read sequential");
    randomRead(9'h1F4, 1, "R3 random read upper half");
    currentRead(1, 1'b0, "R5 pointer advanced after random read");
    randomRead(9'h0FE, 4, "R7 sequential across halves");
    randomRead(9'h1FE, 3, "R10 wrap 511 to 0");

    wrCtl = 1'b1;
    randomRead(9'h033, 2, "R1 write control high");
    wrCtl = 1'b0;
    busStart();
    wrCtl = 1'b1; waitN(2); wrCtl = 1'b0;
    sendByte(hdr(STRAP, 1'b0, 1'b1), ackd);
    checkEq("R1 ack with write control toggled", ackd, 1);
    readN(1, "R1 data with write control toggled");
    finishRead("R1");

    // Wrong type identifier: no ack, bus ignored until next start
    busStart();
    sendByte(8'b1011_1001, ackd);
    checkEq("R9 wrong type no ack", ackd, 0);
    sendByte(8'h00, ackd);
    checkEq("R9 ignored until start", ackd, 0);
    busStop();
    currentRead(1, 1'b0, "R9 pointer unaffected by rejected code");

    // Wrong strap bits
    busStart();
    sendByte({4'b1010, 2'b01, 1'b0, 1'b1}, ackd);
    checkEq("R9 strap mismatch no ack", ackd, 0);
    busStop();

    // Read select differing in bit 1 from the write select
    busStart();
    sendByte(hdr(STRAP, 1'b1, 1'b0), ackd);
    checkEq("R2 write select ack", ackd, 1);
    sendByte(8'h10, ackd);
    checkEq("R2 address ack", ackd, 1);
    modelAddr = 9'h110;
    busRepStart();
    sendByte(hdr(STRAP, 1'b0, 1'b1), ackd);
    checkEq("R8 mismatched read select no ack", ackd, 0);
    readByte(1'b0, got);
    checkEq("R8 target stays off bus", got, 8'hFF);
    busStop();
    currentRead(1, 1'b0, "R2 pointer loaded and memory unchanged");

    // Stop in the middle of a header sequence
    busStart();
    sendByte(hdr(STRAP, 1'b0, 1'b0), ackd);
    checkEq("R11 write select ack before stop", ackd, 1);
    busStop();
    waitN(1);
    checkEq("R11 released after stop", sdaDriveLow, 0);
    currentRead(1, 1'b0, "R11 idle then current read");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule